// File: doc/BRIEF.md
# Command/Response Buffer Control Engine

This block is the control-area state machine that sits behind a memory-mapped command/response buffer. A host talks to it through a simple word-wide register port: it asks the device to wake into a ready state or drop back to idle, it places a command in a shared data window, it launches execution, and it can abort a command that is running. The device answers each host request by clearing the bit the host set. A status word shows whether the device is idle and whether a handshake has ever missed its deadline.

The device holds four states: idle, ready, executing and complete. A ready or idle request is acknowledged only once the external `pwrSettled` input reports that the power domain has settled. While a request waits, a counter runs. If the wait reaches `TIMEOUT_CYC` cycles, a sticky fatal flag is raised. The request still stays pending until `pwrSettled` arrives.

Execution is handled by a stub engine with a fixed latency of `EXEC_LAT` cycles. When it finishes, it replaces the first buffer word with its bitwise inverse. An abort replaces that word with a fixed cancelled code instead. Writes update state on the rising clock edge. Reads are combinational from `rdAddr`.

Top module: `crb_ctrl_area`

## Requirements
- R1: After reset the status word (offset 0x44) reads 0x2 (bit 1 idle set, bit 0 fatal clear), and the request (0x40), cancel (0x48) and start (0x4C) words read 0.
- R2: Writing bit 0 of 0x40 in the idle or complete state sets that bit. Once `pwrSettled` is high, the next clock clears it, enters ready and clears status bit 1.
- R3: Writing bit 1 of 0x40 is accepted only in the ready or complete state. The bit is then cleared on acknowledge and status bit 1 is set. In any other state the write leaves 0x40 reading 0.
- R4: Writing 0x1 to 0x4C in the ready state starts execution. The start word reads 1 for `EXEC_LAT` clocks after the write edge, then reads 0 when the complete state is entered.
- R5: A start write in any state other than ready is ignored: the start word stays 0 and the state is unchanged.
- R6: On normal completion the buffer word at 0x80 becomes the bitwise inverse of its previous value. Other buffer words are left unchanged.
- R7: The cancel word at 0x48 reads back the last bit 0 written to it. Writing 0x0 clears it.
- R8: With cancel set during execution, the next clock enters the complete state, clears the start word, and writes `CANCEL_CODE` (default 0x00000101) to the buffer word at 0x80.
- R9: If a ready or idle request stays pending for `TIMEOUT_CYC` cycles without `pwrSettled`, status bit 0 becomes 1 and stays 1 until reset. The request remains pending until it is acknowledged.
- R10: Host writes to 0x80 + 4k for k below `BUF_BYTES`/4 are stored in the shared buffer and read back at the same address, up to the last word at 0x80 + `BUF_BYTES` - 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrSettled | input | 1 | Power domain settled; allows acknowledge of ready/idle requests |
| hostWr | input | 1 | Host write strobe |
| wrAddr | input | 12 | Byte offset of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 12 | Byte offset of the combinational read |
| rdData | output | 32 | Read data |

## Verification
The hardest situation to reach is a handshake deadline miss, because the acknowledge normally follows the request by one clock. The bench holds `pwrSettled` low while it issues a ready request, then lets more than `TIMEOUT_CYC` clocks pass. It checks that the fatal flag is set and the request is still pending. It then releases `pwrSettled` and checks that the acknowledge still completes while the flag stays set. An abort is timed by issuing the cancel a few clocks into a run that is set up to last longer.

// File: rtl/crb_pkg.sv
`timescale 1ns/1ps
package crb_pkg;
  localparam int CRB_ADDR_W = 12;
  localparam logic [CRB_ADDR_W-1:0] OFF_REQ    = 12'h040;
  localparam logic [CRB_ADDR_W-1:0] OFF_STAT   = 12'h044;
  localparam logic [CRB_ADDR_W-1:0] OFF_CANCEL = 12'h048;
  localparam logic [CRB_ADDR_W-1:0] OFF_START  = 12'h04C;
  localparam logic [CRB_ADDR_W-1:0] OFF_BUF    = 12'h080;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DONE  = 2'd3
  } crbState_t;

  typedef struct packed {
    logic wrDone;
    logic wrCancel;
  } crbStrobe_t;
endpackage

// File: rtl/crb_ctrl_fsm.sv
`timescale 1ns/1ps
module crb_ctrl_fsm
  import crb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000,
  parameter int EXEC_LAT    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pwrSettled,
  input  logic                  hostWr,
  input  logic [CRB_ADDR_W-1:0] wrAddr,
  input  logic [1:0]            wrBits,
  input  logic [CRB_ADDR_W-1:0] rdAddr,
  output logic [31:0]           ctrlRd,
  output crbStrobe_t            strb
);
  localparam int EXEC_W = (EXEC_LAT > 1) ? $clog2(EXEC_LAT) : 1;
  localparam int WAIT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

  crbState_t         state;
  logic              reqReady, reqIdle, cancelReg, startReg, fatal;
  logic [EXEC_W-1:0] execCnt;
  logic [WAIT_W-1:0] waitCnt;

  logic wrReq, wrCancel, wrStart, pending, execLast;
  assign wrReq    = hostWr && (wrAddr == OFF_REQ);
  assign wrCancel = hostWr && (wrAddr == OFF_CANCEL);
  assign wrStart  = hostWr && (wrAddr == OFF_START);
  assign pending  = reqReady || reqIdle;
  assign execLast = (execCnt == EXEC_W'(EXEC_LAT - 1));

  assign strb.wrCancel = (state == ST_EXEC) && cancelReg;
  assign strb.wrDone   = (state == ST_EXEC) && !cancelReg && execLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      reqReady  <= 1'b0;
      reqIdle   <= 1'b0;
      cancelReg <= 1'b0;
      startReg  <= 1'b0;
      fatal     <= 1'b0;
      execCnt   <= '0;
      waitCnt   <= '0;
    end else begin
      // acknowledge of power handshake
      if (reqReady && pwrSettled) begin
        reqReady <= 1'b0;
        state    <= ST_READY;
      end else if (reqIdle && pwrSettled) begin
        reqIdle <= 1'b0;
        state   <= ST_IDLE;
      end
      // deadline counter
      if (pending && !pwrSettled) begin
        if (waitCnt == WAIT_W'(TIMEOUT_CYC - 1)) fatal <= 1'b1;
        else waitCnt <= waitCnt + 1'b1;
      end else begin
        waitCnt <= '0;
      end
      // new requests
      if (wrReq && !pending) begin
        if (wrBits[0] && state != ST_EXEC) reqReady <= 1'b1;
        else if (wrBits[1] && (state == ST_READY || state == ST_DONE)) reqIdle <= 1'b1;
      end
      if (wrCancel) cancelReg <= wrBits[0];
      // execution
      if (wrStart && wrBits[0] && state == ST_READY && !pending) begin
        startReg <= 1'b1;
        state    <= ST_EXEC;
        execCnt  <= '0;
      end else if (state == ST_EXEC) begin
        if (cancelReg || execLast) begin
          startReg <= 1'b0;
          state    <= ST_DONE;
        end else begin
          execCnt <= execCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrlRd = '0;
    unique case (rdAddr)
      OFF_REQ:    ctrlRd = {30'd0, reqIdle, reqReady};
      OFF_STAT:   ctrlRd = {30'd0, (state == ST_IDLE), fatal};
      OFF_CANCEL: ctrlRd = {31'd0, cancelReg};
      OFF_START:  ctrlRd = {31'd0, startReg};
      default:    ctrlRd = '0;
    endcase
  end

  AST_START_FROM_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startReg) |-> $past(state) == ST_READY); // R5
  AST_EXEC_HOLDS_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC) |-> startReg); // R4
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fatal |=> fatal); // R9
  AST_IDLE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_IDLE) |-> !reqIdle); // R3
  AST_CANCEL_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC && cancelReg) |=> (state == ST_DONE && !startReg)); // R8
endmodule

// File: rtl/crb_data_buf.sv
`timescale 1ns/1ps
module crb_data_buf
  import crb_pkg::*;
#(
  parameter int          BUF_BYTES   = 3968,
  parameter logic [31:0] CANCEL_CODE = 32'h0000_0101
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostWr,
  input  logic [CRB_ADDR_W-1:0] wrAddr,
  input  logic [31:0]           wrData,
  input  logic [CRB_ADDR_W-1:0] rdAddr,
  input  crbStrobe_t            strb,
  output logic [31:0]           dataRd
);
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int IDX_W     = $clog2(BUF_WORDS);

  logic [31:0] mem [BUF_WORDS];

  logic [CRB_ADDR_W-1:0] wrIdx, rdIdx;
  logic wrIn, rdIn;
  assign wrIdx = CRB_ADDR_W'((wrAddr - OFF_BUF) >> 2);
  assign rdIdx = CRB_ADDR_W'((rdAddr - OFF_BUF) >> 2);
  assign wrIn  = (wrAddr >= OFF_BUF) && (wrIdx < CRB_ADDR_W'(BUF_WORDS));
  assign rdIn  = (rdAddr >= OFF_BUF) && (rdIdx < CRB_ADDR_W'(BUF_WORDS));

  always_ff @(posedge clk) begin
    if (strb.wrCancel) mem[0] <= CANCEL_CODE;
    else if (strb.wrDone) mem[0] <= ~mem[0];
    if (hostWr && wrIn && !((strb.wrCancel || strb.wrDone) && wrIdx == '0))
      mem[wrIdx[IDX_W-1:0]] <= wrData;
  end

  assign dataRd = rdIn ? mem[rdIdx[IDX_W-1:0]] : '0;

  AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDone, strb.wrCancel})); // R6
endmodule

// File: rtl/crb_ctrl_area.sv
`timescale 1ns/1ps
module crb_ctrl_area
  import crb_pkg::*;
#(
  parameter int          TIMEOUT_CYC = 1000,
  parameter int          EXEC_LAT    = 8,
  parameter int          BUF_BYTES   = 3968,
  parameter logic [31:0] CANCEL_CODE = 32'h0000_0101
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrSettled,
  input  logic        hostWr,
  input  logic [11:0] wrAddr,
  input  logic [31:0] wrData,
  input  logic [11:0] rdAddr,
  output logic [31:0] rdData
);
  crbStrobe_t  strb;
  logic [31:0] ctrlRd, dataRd;

  crb_ctrl_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC), .EXEC_LAT(EXEC_LAT)) u_fsm (
    .clk(clk), .rstN(rstN), .pwrSettled(pwrSettled), .hostWr(hostWr),
    .wrAddr(wrAddr), .wrBits(wrData[1:0]), .rdAddr(rdAddr),
    .ctrlRd(ctrlRd), .strb(strb)
  );

  crb_data_buf #(.BUF_BYTES(BUF_BYTES), .CANCEL_CODE(CANCEL_CODE)) u_buf (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .strb(strb), .dataRd(dataRd)
  );

  assign rdData = (rdAddr >= OFF_BUF) ? dataRd : ctrlRd;
endmodule

// File: tb/sim_crb_ctrl_area.sv
`timescale 1ns/1ps
module sim_crb_ctrl_area;
  localparam int TO  = 16;
  localparam int LAT = 8;
  localparam logic [31:0] CCODE = 32'h0000_0101;

  logic clk = 1'b0, rstN = 1'b0, pwrSettled = 1'b1, hostWr = 1'b0;
  logic [11:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  logic [11:0] qAddr[$];
  logic [31:0] qExp[$];
  string       qTag[$];

  always #2 clk = ~clk;

  crb_ctrl_area #(.TIMEOUT_CYC(TO), .EXEC_LAT(LAT), .CANCEL_CODE(CCODE)) u0 (
    .clk(clk), .rstN(rstN), .pwrSettled(pwrSettled), .hostWr(hostWr),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  // monitor: pops expected reads and compares
  initial begin
    forever begin
      wait (qAddr.size() > 0);
      rdAddr = qAddr[0];
      #1;
      nTests++;
      if (rdData !== qExp[0]) begin
        nFail++;
        $display("FAIL %s addr=%h actual=%h expected=%h", qTag[0], qAddr[0], rdData, qExp[0]);
      end
      void'(qAddr.pop_front()); void'(qExp.pop_front()); void'(qTag.pop_front());
    end
  end

  task automatic expectRd(input logic [11:0] a, input logic [31:0] e, input string t);
    qAddr.push_back(a); qExp.push_back(e); qTag.push_back(t);
    wait (qAddr.size() == 0);
  endtask

  task automatic hostWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWr = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(1);
    expectRd(12'h044, 32'h2, "R1 status");
    expectRd(12'h040, 32'h0, "R1 request");
    expectRd(12'h048, 32'h0, "R1 cancel");
    expectRd(12'h04C, 32'h0, "R1 start");

    hostWrite(12'h04C, 32'h1);
    expectRd(12'h04C, 32'h0, "R5 start in idle");
    expectRd(12'h044, 32'h2, "R5 still idle");

    hostWrite(12'h040, 32'h2);
    expectRd(12'h040, 32'h0, "R3 go-idle in idle");

    hostWrite(12'h080, 32'hA5A5_0F0F);
    hostWrite(12'h084, 32'h1234_5678);
    hostWrite(12'h080 + 12'(4 * 991), 32'hDEAD_BEEF);
    expectRd(12'h084, 32'h1234_5678, "R10 word1");
    expectRd(12'h080 + 12'(4 * 991), 32'hDEAD_BEEF, "R10 last word");

    hostWrite(12'h040, 32'h1);
    expectRd(12'h040, 32'h1, "R2 request pending");
    tick(1);
    expectRd(12'h040, 32'h0, "R2 request acked");
    expectRd(12'h044, 32'h0, "R2 idle cleared");

    hostWrite(12'h04C, 32'h1);
    expectRd(12'h04C, 32'h1, "R4 start set");
    tick(LAT - 1);
    expectRd(12'h04C, 32'h1, "R4 still running");
    tick(1);
    expectRd(12'h04C, 32'h0, "R4 start cleared");
    expectRd(12'h080, 32'h5A5A_F0F0, "R6 word0 inverted");
    expectRd(12'h084, 32'h1234_5678, "R6 word1 untouched");

    hostWrite(12'h040, 32'h2);
    tick(1);
    expectRd(12'h040, 32'h0, "R3 go-idle acked");
    expectRd(12'h044, 32'h2, "R3 idle from done");

    hostWrite(12'h040, 32'h1);
    tick(1);
    hostWrite(12'h04C, 32'h1);
    tick(2);
    hostWrite(12'h048, 32'h1);
    expectRd(12'h048, 32'h1, "R7 cancel readback");
    tick(1);
    expectRd(12'h04C, 32'h0, "R8 start cleared by cancel");
    expectRd(12'h080, CCODE, "R8 cancelled code");
    hostWrite(12'h048, 32'h0);
    expectRd(12'h048, 32'h0, "R7 cancel cleared");

    hostWrite(12'h040, 32'h1);
    tick(1);
    expectRd(12'h044, 32'h0, "R2 ready from done");
    hostWrite(12'h040, 32'h2);
    tick(1);
    expectRd(12'h044, 32'h2, "R3 idle from ready");

    pwrSettled = 1'b0;
    hostWrite(12'h040, 32'h1);
    tick(TO + 4);
    expectRd(12'h044, 32'h3, "R9 fatal set");
    expectRd(12'h040, 32'h1, "R9 request pending");
    pwrSettled = 1'b1;
    tick(1);
    expectRd(12'h040, 32'h0, "R9 late ack");
    expectRd(12'h044, 32'h1, "R9 fatal sticky");

    done = 1'b1;
    finishRun();
  end
endmodule